// File: doc/BRIEF.md
# Binary Arithmetic Decoding Engine

This block is the arithmetic core of a context-adaptive binary entropy decoder. It holds a 9-bit interval width and a 9-bit offset into that interval. Each request it accepts produces one decoded bin. It pulls compressed bits one at a time from a valid/ready bit stream.

A request is one of three kinds. An initialisation request starts a slice. A regular request decodes a bin under a 7-bit context state supplied by the caller, and the engine returns the updated state so that an outside context memory can store it. A bypass request decodes a bin with equal odds for both values. The probability tables are built into the block.

Both handshakes follow the same rule: a transfer happens on a rising edge where valid and ready are both high. The request port is ready only while the engine is idle. The bit port is ready only while the engine needs another input bit. A low `bit_valid` stalls the engine with its registers held. The result is a one-cycle strobe and cannot be held back, so the consumer must always accept it.

Top module: `cabad_engine`

## Requirements
- R1: A request with mode 2'b00 sets the width to 0x1FE and shifts exactly nine input bits into the offset, first bit at the MSB. The result strobe then rises with bin 0.
- R2: A request with mode 2'b01 reads the context state as index = state[6:1] and MPS bit = state[0]. It takes the LPS width from the fixed table at (index, width bits [7:6]). The bin is the MPS bit when the offset is below width minus LPS width, and its inverse otherwise. On an LPS the offset drops by the MPS width and the width becomes the LPS width.
- R3: After a regular MPS bin, the returned state keeps the MPS bit and raises the index by one, saturating at 62.
- R4: After a regular LPS bin, the returned index comes from the fixed LPS transition table, and the MPS bit is inverted only when the old index was 0.
- R5: After a regular bin the engine doubles the width, and shifts one new input bit into the offset LSB, until the width MSB is 1. Over a whole slice, the bits consumed equal the bits the matching encoder wrote.
- R6: A request with mode 2'b10 or 2'b11 is a bypass bin. It shifts one input bit into the offset and compares the result with the unchanged width. The bin is 1 when the offset is greater or equal, and the width is then subtracted from it.
- R7: `bit_ready` is high only while the engine waits for an input bit. A low `bit_valid` stalls decoding without losing or duplicating bits.
- R8: `req_ready` is high only while idle. An accepted request produces exactly one single-cycle `res_valid`.
- R9: During and right after reset, `req_ready` is 1 and both `res_valid` and `bit_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_mode | input | 2 | 00 init, 01 regular, 1x bypass |
| req_state | input | 7 | Context state {index[5:0], mps} |
| bit_valid | input | 1 | Input bit offered |
| bit_ready | output | 1 | Engine wants an input bit |
| bit_data | input | 1 | Compressed input bit |
| res_valid | output | 1 | One-cycle result strobe |
| res_bin | output | 1 | Decoded bin |
| res_state | output | 7 | Updated context state (regular requests) |

## Verification
The bench builds the engine with its default widths: a 6-bit state index and a 9-bit interval. These are the only widths the built-in tables fit, and they bring the whole state range within reach, including saturation at index 62 and the MPS flip at index 0. Stimulus comes from an encoder model in the bench, run over several slices. The slices mix long MPS runs, LPS-heavy runs that force multi-bit renormalisation, and bypass bins, while gaps in the bit stream exercise the stall path.

// File: rtl/cabad_pkg.sv
package cabad_pkg;
  typedef enum logic [1:0] {
    MODE_INIT = 2'b00,
    MODE_REG  = 2'b01,
    MODE_BYP  = 2'b10,
    MODE_BYP2 = 2'b11
  } req_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_NORM = 2'd2,
    ST_BYP  = 2'd3
  } eng_state_e;
endpackage

// File: rtl/cabad_lps_rom.sv
module cabad_lps_rom #(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       quart,
  output logic [7:0]       lps_width,
  output logic [IDX_W-1:0] lps_next
);
  logic [31:0] row;

  always_comb begin
    case (idx)
      6'd0:  row = {8'd128, 8'd176, 8'd208, 8'd240};
      6'd1:  row = {8'd128, 8'd167, 8'd197, 8'd227};
      6'd2:  row = {8'd128, 8'd158, 8'd187, 8'd216};
      6'd3:  row = {8'd123, 8'd150, 8'd178, 8'd205};
      6'd4:  row = {8'd116, 8'd142, 8'd169, 8'd195};
      6'd5:  row = {8'd111, 8'd135, 8'd160, 8'd185};
      6'd6:  row = {8'd105, 8'd128, 8'd152, 8'd175};
      6'd7:  row = {8'd100, 8'd122, 8'd144, 8'd166};
      6'd8:  row = {8'd95,  8'd116, 8'd137, 8'd158};
      6'd9:  row = {8'd90,  8'd110, 8'd130, 8'd150};
      6'd10: row = {8'd85,  8'd104, 8'd123, 8'd142};
      6'd11: row = {8'd81,  8'd99,  8'd117, 8'd135};
      6'd12: row = {8'd77,  8'd94,  8'd111, 8'd128};
      6'd13: row = {8'd73,  8'd89,  8'd105, 8'd122};
      6'd14: row = {8'd69,  8'd85,  8'd100, 8'd116};
      6'd15: row = {8'd66,  8'd80,  8'd95,  8'd110};
      6'd16: row = {8'd62,  8'd76,  8'd90,  8'd104};
      6'd17: row = {8'd59,  8'd72,  8'd86,  8'd99};
      6'd18: row = {8'd56,  8'd69,  8'd81,  8'd94};
      6'd19: row = {8'd53,  8'd65,  8'd77,  8'd89};
      6'd20: row = {8'd51,  8'd62,  8'd73,  8'd85};
      6'd21: row = {8'd48,  8'd59,  8'd69,  8'd80};
      6'd22: row = {8'd46,  8'd56,  8'd66,  8'd76};
      6'd23: row = {8'd43,  8'd53,  8'd63,  8'd72};
      6'd24: row = {8'd41,  8'd50,  8'd59,  8'd69};
      6'd25: row = {8'd39,  8'd48,  8'd56,  8'd65};
      6'd26: row = {8'd37,  8'd45,  8'd54,  8'd62};
      6'd27: row = {8'd35,  8'd43,  8'd51,  8'd59};
      6'd28: row = {8'd33,  8'd41,  8'd48,  8'd56};
      6'd29: row = {8'd32,  8'd39,  8'd46,  8'd53};
      6'd30: row = {8'd30,  8'd37,  8'd43,  8'd50};
      6'd31: row = {8'd29,  8'd35,  8'd41,  8'd48};
      6'd32: row = {8'd27,  8'd33,  8'd39,  8'd45};
      6'd33: row = {8'd26,  8'd31,  8'd37,  8'd43};
      6'd34: row = {8'd24,  8'd30,  8'd35,  8'd41};
      6'd35: row = {8'd23,  8'd28,  8'd33,  8'd39};
      6'd36: row = {8'd22,  8'd27,  8'd32,  8'd37};
      6'd37: row = {8'd21,  8'd26,  8'd30,  8'd35};
      6'd38: row = {8'd20,  8'd24,  8'd29,  8'd33};
      6'd39: row = {8'd19,  8'd23,  8'd27,  8'd31};
      6'd40: row = {8'd18,  8'd22,  8'd26,  8'd30};
      6'd41: row = {8'd17,  8'd21,  8'd25,  8'd28};
      6'd42: row = {8'd16,  8'd20,  8'd23,  8'd27};
      6'd43: row = {8'd15,  8'd19,  8'd22,  8'd25};
      6'd44: row = {8'd14,  8'd18,  8'd21,  8'd24};
      6'd45: row = {8'd14,  8'd17,  8'd20,  8'd23};
      6'd46: row = {8'd13,  8'd16,  8'd19,  8'd22};
      6'd47: row = {8'd12,  8'd15,  8'd18,  8'd21};
      6'd48: row = {8'd12,  8'd14,  8'd17,  8'd20};
      6'd49: row = {8'd11,  8'd14,  8'd16,  8'd19};
      6'd50: row = {8'd11,  8'd13,  8'd15,  8'd18};
      6'd51: row = {8'd10,  8'd12,  8'd15,  8'd17};
      6'd52: row = {8'd10,  8'd12,  8'd14,  8'd16};
      6'd53: row = {8'd9,   8'd11,  8'd13,  8'd15};
      6'd54: row = {8'd9,   8'd11,  8'd12,  8'd14};
      6'd55: row = {8'd8,   8'd10,  8'd12,  8'd14};
      6'd56: row = {8'd8,   8'd9,   8'd11,  8'd13};
      6'd57: row = {8'd7,   8'd9,   8'd11,  8'd12};
      6'd58: row = {8'd7,   8'd9,   8'd10,  8'd12};
      6'd59: row = {8'd7,   8'd8,   8'd10,  8'd11};
      6'd60: row = {8'd6,   8'd8,   8'd9,   8'd11};
      6'd61: row = {8'd6,   8'd7,   8'd9,   8'd10};
      6'd62: row = {8'd6,   8'd7,   8'd8,   8'd9};
      default: row = {8'd2, 8'd2,   8'd2,   8'd2};
    endcase
  end

  assign lps_width = row[8*(3-int'(quart)) +: 8];

  always_comb begin
    case (idx)
      6'd0, 6'd1:                  lps_next = 6'd0;
      6'd2:                        lps_next = 6'd1;
      6'd3, 6'd4:                  lps_next = 6'd2;
      6'd5, 6'd6:                  lps_next = 6'd4;
      6'd7:                        lps_next = 6'd5;
      6'd8:                        lps_next = 6'd6;
      6'd9:                        lps_next = 6'd7;
      6'd10:                       lps_next = 6'd8;
      6'd11, 6'd12:                lps_next = 6'd9;
      6'd13, 6'd14:                lps_next = 6'd11;
      6'd15:                       lps_next = 6'd12;
      6'd16, 6'd17:                lps_next = 6'd13;
      6'd18, 6'd19:                lps_next = 6'd15;
      6'd20, 6'd21:                lps_next = 6'd16;
      6'd22, 6'd23:                lps_next = 6'd18;
      6'd24, 6'd25:                lps_next = 6'd19;
      6'd26, 6'd27:                lps_next = 6'd21;
      6'd28, 6'd29:                lps_next = 6'd22;
      6'd30:                       lps_next = 6'd23;
      6'd31, 6'd32:                lps_next = 6'd24;
      6'd33:                       lps_next = 6'd25;
      6'd34, 6'd35:                lps_next = 6'd26;
      6'd36, 6'd37:                lps_next = 6'd27;
      6'd38:                       lps_next = 6'd28;
      6'd39, 6'd40:                lps_next = 6'd29;
      6'd41, 6'd42, 6'd43:         lps_next = 6'd30;
      6'd44:                       lps_next = 6'd31;
      6'd45, 6'd46:                lps_next = 6'd32;
      6'd47, 6'd48, 6'd49:         lps_next = 6'd33;
      6'd50, 6'd51:                lps_next = 6'd34;
      6'd52, 6'd53, 6'd54:         lps_next = 6'd35;
      6'd55, 6'd56, 6'd57:         lps_next = 6'd36;
      6'd58, 6'd59, 6'd60:         lps_next = 6'd37;
      6'd61, 6'd62:                lps_next = 6'd38;
      default:                     lps_next = 6'd63;
    endcase
  end
endmodule

// File: rtl/cabad_ctx_next.sv
module cabad_ctx_next #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [IDX_W:0]   state_in,
  input  logic             is_lps,
  input  logic [IDX_W-1:0] lps_next,
  output logic [IDX_W:0]   state_out
);
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'((1 << IDX_W) - 2);

  logic [IDX_W-1:0] idx;
  logic             mps;
  logic [IDX_W-1:0] mps_next;

  assign idx      = state_in[IDX_W:1];
  assign mps      = state_in[0];
  assign mps_next = (idx >= MAX_IDX) ? MAX_IDX : idx + 1'b1;

  always_comb begin
    if (is_lps) state_out = {lps_next, (idx == '0) ? ~mps : mps};
    else        state_out = {mps_next, mps};
  end

  AST_MPS_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !is_lps && state_in[IDX_W:1] <= MAX_IDX) |-> (state_out[IDX_W:1] <= MAX_IDX)); // R3
  AST_LPS_FLIP_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && is_lps && state_in[IDX_W:1] != '0) |-> (state_out[0] == state_in[0])); // R4
endmodule

// File: rtl/cabad_engine.sv
module cabad_engine
  import cabad_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int RANGE_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_mode,
  input  logic [IDX_W:0]     req_state,
  input  logic               bit_valid,
  output logic               bit_ready,
  input  logic               bit_data,
  output logic               res_valid,
  output logic               res_bin,
  output logic [IDX_W:0]     res_state
);
  localparam int CNT_W = $clog2(RANGE_W + 1);
  localparam logic [RANGE_W-1:0] RANGE_INIT = RANGE_W'((1 << RANGE_W) - 2);

  eng_state_e         st_q;
  logic [RANGE_W-1:0] range_q, offset_q;
  logic [CNT_W-1:0]   fill_cnt_q;

  logic [7:0]         lps_w;
  logic [IDX_W-1:0]   lps_nxt;
  logic [RANGE_W-1:0] rmps;
  logic               is_lps;
  logic [IDX_W:0]     st_upd;
  logic [RANGE_W:0]   byp_t, byp_sub;
  logic               accept;

  cabad_lps_rom #(.IDX_W(IDX_W)) u_rom (
    .idx      (req_state[IDX_W:1]),
    .quart    (range_q[RANGE_W-2 -: 2]),
    .lps_width(lps_w),
    .lps_next (lps_nxt)
  );

  assign rmps   = range_q - {{(RANGE_W-8){1'b0}}, lps_w};
  assign is_lps = (offset_q >= rmps);
  assign accept = req_valid && req_ready;

  cabad_ctx_next #(.IDX_W(IDX_W)) u_ctx (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (accept && (req_mode == MODE_REG)),
    .state_in (req_state),
    .is_lps   (is_lps),
    .lps_next (lps_nxt),
    .state_out(st_upd)
  );

  assign byp_t   = {offset_q, bit_data};
  assign byp_sub = byp_t - {1'b0, range_q};

  assign req_ready = (st_q == ST_IDLE);
  assign bit_ready = (st_q == ST_FILL) || (st_q == ST_BYP) ||
                     ((st_q == ST_NORM) && !range_q[RANGE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      range_q    <= RANGE_INIT;
      offset_q   <= '0;
      fill_cnt_q <= '0;
      res_valid  <= 1'b0;
      res_bin    <= 1'b0;
      res_state  <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          case (req_mode)
            MODE_INIT: begin
              range_q    <= RANGE_INIT;
              offset_q   <= '0;
              fill_cnt_q <= CNT_W'(RANGE_W);
              res_bin    <= 1'b0;
              res_state  <= req_state;
              st_q       <= ST_FILL;
            end
            MODE_REG: begin
              res_state <= st_upd;
              if (is_lps) begin
                res_bin  <= ~req_state[0];
                offset_q <= offset_q - rmps;
                range_q  <= {{(RANGE_W-8){1'b0}}, lps_w};
              end else begin
                res_bin <= req_state[0];
                range_q <= rmps;
              end
              st_q <= ST_NORM;
            end
            default: begin
              res_state <= req_state;
              st_q      <= ST_BYP;
            end
          endcase
        end
        ST_FILL: if (bit_valid) begin
          offset_q   <= {offset_q[RANGE_W-2:0], bit_data};
          fill_cnt_q <= fill_cnt_q - 1'b1;
          if (fill_cnt_q == CNT_W'(1)) begin
            res_valid <= 1'b1;
            st_q      <= ST_IDLE;
          end
        end
        ST_NORM: begin
          if (range_q[RANGE_W-1]) begin
            res_valid <= 1'b1;
            st_q      <= ST_IDLE;
          end else if (bit_valid) begin
            range_q  <= {range_q[RANGE_W-2:0], 1'b0};
            offset_q <= {offset_q[RANGE_W-2:0], bit_data};
          end
        end
        ST_BYP: if (bit_valid) begin
          if (byp_t >= {1'b0, range_q}) begin
            res_bin  <= 1'b1;
            offset_q <= byp_sub[RANGE_W-1:0];
          end else begin
            res_bin  <= 1'b0;
            offset_q <= byp_t[RANGE_W-1:0];
          end
          res_valid <= 1'b1;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_RANGE_NORMALISED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_NORM) |-> range_q[RANGE_W-1]); // R5
  AST_STALL_HOLDS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && !bit_valid) |=> $stable(offset_q)); // R7
  AST_BYPASS_KEEPS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BYP) |=> $stable(range_q)); // R6
  AST_RESULT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R8
  AST_INIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == MODE_INIT) |=> (range_q == RANGE_INIT)); // R1
endmodule

// File: tb/cabad_engine_tb_top.sv
module cabad_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic [6:0] req_state = '0;
  logic req_ready, bit_ready, res_valid, res_bin;
  logic [6:0] res_state;

  always #2ns clk = ~clk;

  cabad_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode), .req_state(req_state),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data),
    .res_valid(res_valid), .res_bin(res_bin), .res_state(res_state)
  );

  typedef struct { int mode; int bin; int st; int bits; } exp_t;
  typedef struct { logic [1:0] mode; logic [6:0] st; } req_t;
  exp_t exp_q[$];
  req_t req_q[$];
  int   bit_q[$];

  int n_chk = 0, n_bad = 0, consumed = 0, produced = 0;
  int e_low, e_range, e_out, e_first;
  int ctx[4];
  bit reqs_done = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int lps_tab(int idx, int q);
    logic [31:0] r;
    case (idx)
      0: r={8'd128,8'd176,8'd208,8'd240};   1: r={8'd128,8'd167,8'd197,8'd227};
      2: r={8'd128,8'd158,8'd187,8'd216};   3: r={8'd123,8'd150,8'd178,8'd205};
      4: r={8'd116,8'd142,8'd169,8'd195};   5: r={8'd111,8'd135,8'd160,8'd185};
      6: r={8'd105,8'd128,8'd152,8'd175};   7: r={8'd100,8'd122,8'd144,8'd166};
      8: r={8'd95,8'd116,8'd137,8'd158};    9: r={8'd90,8'd110,8'd130,8'd150};
      10: r={8'd85,8'd104,8'd123,8'd142};   11: r={8'd81,8'd99,8'd117,8'd135};
      12: r={8'd77,8'd94,8'd111,8'd128};    13: r={8'd73,8'd89,8'd105,8'd122};
      14: r={8'd69,8'd85,8'd100,8'd116};    15: r={8'd66,8'd80,8'd95,8'd110};
      16: r={8'd62,8'd76,8'd90,8'd104};     17: r={8'd59,8'd72,8'd86,8'd99};
      18: r={8'd56,8'd69,8'd81,8'd94};      19: r={8'd53,8'd65,8'd77,8'd89};
      20: r={8'd51,8'd62,8'd73,8'd85};      21: r={8'd48,8'd59,8'd69,8'd80};
      22: r={8'd46,8'd56,8'd66,8'd76};      23: r={8'd43,8'd53,8'd63,8'd72};
      24: r={8'd41,8'd50,8'd59,8'd69};      25: r={8'd39,8'd48,8'd56,8'd65};
      26: r={8'd37,8'd45,8'd54,8'd62};      27: r={8'd35,8'd43,8'd51,8'd59};
      28: r={8'd33,8'd41,8'd48,8'd56};      29: r={8'd32,8'd39,8'd46,8'd53};
      30: r={8'd30,8'd37,8'd43,8'd50};      31: r={8'd29,8'd35,8'd41,8'd48};
      32: r={8'd27,8'd33,8'd39,8'd45};      33: r={8'd26,8'd31,8'd37,8'd43};
      34: r={8'd24,8'd30,8'd35,8'd41};      35: r={8'd23,8'd28,8'd33,8'd39};
      36: r={8'd22,8'd27,8'd32,8'd37};      37: r={8'd21,8'd26,8'd30,8'd35};
      38: r={8'd20,8'd24,8'd29,8'd33};      39: r={8'd19,8'd23,8'd27,8'd31};
      40: r={8'd18,8'd22,8'd26,8'd30};      41: r={8'd17,8'd21,8'd25,8'd28};
      42: r={8'd16,8'd20,8'd23,8'd27};      43: r={8'd15,8'd19,8'd22,8'd25};
      44: r={8'd14,8'd18,8'd21,8'd24};      45: r={8'd14,8'd17,8'd20,8'd23};
      46: r={8'd13,8'd16,8'd19,8'd22};      47: r={8'd12,8'd15,8'd18,8'd21};
      48: r={8'd12,8'd14,8'd17,8'd20};      49: r={8'd11,8'd14,8'd16,8'd19};
      50: r={8'd11,8'd13,8'd15,8'd18};      51: r={8'd10,8'd12,8'd15,8'd17};
      52: r={8'd10,8'd12,8'd14,8'd16};      53: r={8'd9,8'd11,8'd13,8'd15};
      54: r={8'd9,8'd11,8'd12,8'd14};       55: r={8'd8,8'd10,8'd12,8'd14};
      56: r={8'd8,8'd9,8'd11,8'd13};        57: r={8'd7,8'd9,8'd11,8'd12};
      58: r={8'd7,8'd9,8'd10,8'd12};        59: r={8'd7,8'd8,8'd10,8'd11};
      60: r={8'd6,8'd8,8'd9,8'd11};         61: r={8'd6,8'd7,8'd9,8'd10};
      62: r={8'd6,8'd7,8'd8,8'd9};
      default: r={8'd2,8'd2,8'd2,8'd2};
    endcase
    return int'(r[8*(3-q) +: 8]);
  endfunction

  function automatic int lps_trans(int idx);
    case (idx)
      0, 1: return 0;  2: return 1;  3, 4: return 2;  5, 6: return 4;
      7: return 5;  8: return 6;  9: return 7;  10: return 8;
      11, 12: return 9;  13, 14: return 11;  15: return 12;  16, 17: return 13;
      18, 19: return 15;  20, 21: return 16;  22, 23: return 18;  24, 25: return 19;
      26, 27: return 21;  28, 29: return 22;  30: return 23;  31, 32: return 24;
      33: return 25;  34, 35: return 26;  36, 37: return 27;  38: return 28;
      39, 40: return 29;  41, 42, 43: return 30;  44: return 31;  45, 46: return 32;
      47, 48, 49: return 33;  50, 51: return 34;  52, 53, 54: return 35;
      55, 56, 57: return 36;  58, 59, 60: return 37;  61, 62: return 38;
      default: return 63;
    endcase
  endfunction

  task automatic put_bit(int b);
    if (e_first != 0) e_first = 0;
    else bit_q.push_back(b);
    while (e_out > 0) begin bit_q.push_back(1 - b); e_out--; end
  endtask

  task automatic enc_flush();
    put_bit((e_low >> 9) & 1);
    for (int i = 8; i >= 0; i--) bit_q.push_back((e_low >> i) & 1);
  endtask

  task automatic enc_init();
    exp_t e; req_t r;
    if (e_first == 0 || e_range != 0) enc_flush();
    e_low = 0; e_range = 510; e_out = 0; e_first = 1;
    e.mode = 0; e.bin = 0; e.st = 0; e.bits = bit_q.size() + 9;
    r.mode = 2'b00; r.st = '0;
    exp_q.push_back(e); req_q.push_back(r);
  endtask

  task automatic enc_reg(int c, int bin);
    exp_t e; req_t r;
    int idx, mps, rl;
    idx = ctx[c] >> 1; mps = ctx[c] & 1;
    r.mode = 2'b01; r.st = 7'(ctx[c]);
    rl = lps_tab(idx, (e_range >> 6) & 3);
    e_range -= rl;
    if (bin != mps) begin
      e_low += e_range; e_range = rl;
      if (idx == 0) mps = 1 - mps;
      idx = lps_trans(idx);
    end else if (idx < 62) idx++;
    while (e_range < 256) begin
      if (e_low < 256) put_bit(0);
      else if (e_low >= 512) begin e_low -= 512; put_bit(1); end
      else begin e_low -= 256; e_out++; end
      e_range <<= 1; e_low <<= 1;
    end
    ctx[c] = (idx << 1) | mps;
    e.mode = (bin == (r.st[0] ? 1 : 0)) ? 1 : 2; e.bin = bin; e.st = ctx[c]; e.bits = 0;
    exp_q.push_back(e); req_q.push_back(r);
  endtask

  task automatic enc_byp(int bin, logic [1:0] md);
    exp_t e; req_t r;
    e_low <<= 1;
    if (bin != 0) e_low += e_range;
    if (e_low >= 1024) begin put_bit(1); e_low -= 1024; end
    else if (e_low < 512) put_bit(0);
    else begin e_low -= 512; e_out++; end
    e.mode = 3; e.bin = bin; e.st = 0; e.bits = 0;
    r.mode = md; r.st = 7'h55;
    exp_q.push_back(e); req_q.push_back(r);
  endtask

  // bit-stream driver with gaps (R7)
  logic [15:0] lf = 16'hACE1;
  bit xfer = 0;
  always @(negedge clk) begin
    if (xfer) begin void'(bit_q.pop_front()); consumed++; end
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    bit_valid = (bit_q.size() > 0) && (lf[1:0] != 2'b00);
    bit_data  = (bit_q.size() > 0) ? bit_q[0][0] : 1'b0;
    #1;
    xfer = bit_valid && bit_ready;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    #2;
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) chk(0, "R8 unexpected result", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        case (e.mode)
          0: begin
            chk(res_bin == 1'b0, "R1 init bin", int'(res_bin), 0);
            chk(consumed == e.bits, "R1 bits taken by init", consumed, e.bits);
          end
          1: begin
            chk(res_bin == e.bin[0], "R2 MPS bin", int'(res_bin), e.bin);
            chk(int'(res_state) == e.st, "R3 MPS state", int'(res_state), e.st);
          end
          2: begin
            chk(res_bin == e.bin[0], "R2 LPS bin", int'(res_bin), e.bin);
            chk(int'(res_state) == e.st, "R4 LPS state", int'(res_state), e.st);
          end
          default: chk(res_bin == e.bin[0], "R6 bypass bin", int'(res_bin), e.bin);
        endcase
      end
    end
  end

  // request driver
  initial begin
    int n;
    for (int c = 0; c < 4; c++) ctx[c] = 0;
    e_range = 0; e_first = 1; e_low = 0; e_out = 0;
    // slice A: two contexts, mostly MPS
    enc_init();
    ctx[0] = (5 << 1) | 0; ctx[1] = (20 << 1) | 1;
    for (int i = 0; i < 40; i++) begin
      int c; c = i % 2;
      enc_reg(c, ((i % 5) == 3) ? 1 - (ctx[c] & 1) : (ctx[c] & 1));
    end
    // slice B: bypass only, both bypass codes
    enc_init();
    for (int i = 0; i < 20; i++) enc_byp(((i * 7) % 3 == 0) ? 1 : 0, (i % 2) ? 2'b11 : 2'b10);
    // slice C: saturation at 62, flip at index 0
    enc_init();
    ctx[2] = (62 << 1) | 1; ctx[3] = (0 << 1) | 0;
    for (int i = 0; i < 4; i++) enc_reg(2, 1);
    enc_reg(3, 1);
    enc_byp(1, 2'b10);
    enc_reg(3, 0);
    enc_reg(2, 0);
    enc_byp(0, 2'b11);
    // slice D: LPS-heavy, long renormalisation
    enc_init();
    ctx[0] = (40 << 1) | 1;
    for (int i = 0; i < 30; i++) begin
      enc_reg(0, ((i % 4) == 0) ? (ctx[0] & 1) : 1 - (ctx[0] & 1));
      if ((i % 7) == 2) enc_byp(i % 2, 2'b10);
    end
    enc_flush();
    produced = bit_q.size();

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    chk(req_ready == 1'b1, "R9 req_ready after reset", int'(req_ready), 1);
    chk(res_valid == 1'b0, "R9 res_valid after reset", int'(res_valid), 0);
    chk(bit_ready == 1'b0, "R9 bit_ready after reset", int'(bit_ready), 0);

    n = req_q.size();
    for (int k = 0; k < n; k++) begin
      req_t r;
      r = req_q.pop_front();
      @(negedge clk);
      req_valid = 1'b1; req_mode = r.mode; req_state = r.st;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(req_ready == 1'b0, "R8 busy after accept", int'(req_ready), 0);
    end
    reqs_done = 1;
  end

  // end of run and watchdog
  initial begin
    int cyc;
    cyc = 0;
    while (!(reqs_done && exp_q.size() == 0) && cyc < 100000) begin
      @(negedge clk); cyc++;
    end
    if (cyc >= 100000) chk(0, "watchdog expired", cyc, 0);
    repeat (4) @(negedge clk);
    chk(consumed == produced, "R5 total bits consumed", consumed, produced);
    chk(bit_q.size() == 0, "R5 bits left over", bit_q.size(), 0);
    chk(bit_ready == 1'b0, "R7 no bit wanted when idle", int'(bit_ready), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule